// File: doc/BRIEF.md
# Frame-Linear Display Timing Generator

This block produces horizontal sync, vertical sync and a data-enable strobe for a digital television style video output, together with a 24-bit RGB pixel stream. All timing is programmed through a small register write port. Horizontal position comes from a per-line pixel counter. Vertical position is not tracked in lines. A second counter runs across the whole frame in pixel clocks, so every vertical quantity (frame period, vsync length, display window start and end) is an absolute pixel-clock count measured from the start of vsync. Software converts line-based mode figures into these counts before it writes them.

Pixels come from an upstream source through a valid/ready pair. Ready is high exactly when data-enable is high. Inside the display window a missing pixel is replaced either by a programmed underflow colour or by black. Outside the window, while the generator runs, the border colour is driven. Timing values are written into a pending set and copied to the active set only at a frame boundary, so no frame mixes old and new timing. Clearing the enable bit does not stop the output at once: the current frame completes, the generator halts when the frame counter wraps, and a one-cycle frame event pulse marks that boundary. The same pulse appears at every wrap, so software can wait on it.

Top module: `dtv_timing_gen`

## Requirements
- R1: After reset the block is stopped, and vid_de, pix_ready, frame_evt and vid_rgb are 0. Both syncs sit at their inactive level (low, because the polarity register resets to 0). All registers reset to 0.
- R2: Address 0 bit 0 is the enable request. When it is set while the block is stopped, the first frame begins after the second rising edge that follows the write strobe. In that first cycle both counters are at 0.
- R3: Address 1 holds the line period P in bits [11:0] and the hsync width W in bits [27:16]. While running, the line counter steps 0 to P-1 and hsync is active in positions 0 to W-1 of each line.
- R4: Address 2 holds the frame period F in pixel clocks and address 3 holds the vsync length L in pixel clocks, both in bits [23:0]. The frame counter steps 0 to F-1, and vsync is active at frame counts 0 to L-1. At each frame wrap the line counter also returns to 0.
- R5: Address 4 holds the horizontal window start in bits [11:0] and the end in bits [27:16]. Both are inclusive line positions counted from the start of hsync.
- R6: Address 5 and address 6 hold the vertical window start and end frame counts, both inclusive, in bits [23:0]. vid_de is high only while running, with both counts inside their windows, and pix_ready equals vid_de.
- R7: At address 10, bit 0 makes hsync active-low and bit 1 makes vsync active-low. A set bit inverts the output in every cycle, stopped cycles included.
- R8: While vid_de and pix_valid are both high, vid_rgb equals pix_data, 8 bits per component in red, green, blue order from the top.
- R9: Address 8 holds the underflow colour in bits [23:0] and the recovery enable in bit 31. While vid_de is high and pix_valid is low, vid_rgb is that colour when recovery is on and 0 when it is off.
- R10: Address 7 holds the border colour in bits [23:0]. While running and outside the display window, vid_rgb is the border colour. While stopped it is 0.
- R11: frame_evt is a one-cycle pulse that follows every cycle in which the frame counter wraps. If the enable request is 0 at a wrap, the block stops at that boundary, so a cleared enable leaves the rest of the current frame untouched.
- R12: Writes to addresses 1 to 6 and to the skew register at address 9 reach the active timing only at a frame wrap or when the block starts. The skew value is added to both vertical window bounds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 32 | Register write data |
| pix_valid | input | 1 | Upstream pixel present |
| pix_data | input | 24 | Upstream pixel, RGB 8:8:8 |
| pix_ready | output | 1 | Pixel consumed this cycle (equals vid_de) |
| vid_rgb | output | 24 | Output colour |
| vid_hsync | output | 1 | Horizontal sync, programmable polarity |
| vid_vsync | output | 1 | Vertical sync, programmable polarity |
| vid_de | output | 1 | Data enable |
| frame_evt | output | 1 | One-cycle pulse after each frame wrap |

## Verification
The bound checker watches the structural rules on every cycle. A stop always coincides with a frame event pulse. Each run begins at the origin of both counters. A stopped block shows no data-enable and black output. Data-enable never appears outside the active horizontal window. The underflow colour replaces missing pixels. Active timing changes only at a frame wrap. The exact positions of sync edges and window bounds, the effect of the polarity bits and skew, the frame in which a mid-frame write first takes hold, and the frame that follows a cleared enable can only be shown by the bench scenarios. Those scenarios compare every output in every cycle against a model derived from the requirements.

// File: rtl/dtv_pkg.sv
// Shared constants and types for the frame-linear timing generator.
// Assumes a 4-bit register address space and 12/24-bit counter widths.
package dtv_pkg;
    localparam int H_W    = 12;   // line position width
    localparam int F_W    = 24;   // frame pixel-count width
    localparam int ADDR_W = 4;

    localparam logic [ADDR_W-1:0] A_CTRL   = 4'd0;
    localparam logic [ADDR_W-1:0] A_HSYNC  = 4'd1;
    localparam logic [ADDR_W-1:0] A_FPER   = 4'd2;
    localparam logic [ADDR_W-1:0] A_VLEN   = 4'd3;
    localparam logic [ADDR_W-1:0] A_HWIN   = 4'd4;
    localparam logic [ADDR_W-1:0] A_VBEG   = 4'd5;
    localparam logic [ADDR_W-1:0] A_VEND   = 4'd6;
    localparam logic [ADDR_W-1:0] A_BORDER = 4'd7;
    localparam logic [ADDR_W-1:0] A_UFLOW  = 4'd8;
    localparam logic [ADDR_W-1:0] A_SKEW   = 4'd9;
    localparam logic [ADDR_W-1:0] A_POL    = 4'd10;

    typedef struct packed {
        logic [H_W-1:0] hper;   // pixels per line
        logic [H_W-1:0] hpw;    // hsync width
        logic [H_W-1:0] hbeg;   // window start in line
        logic [H_W-1:0] hend;   // window end in line, inclusive
        logic [F_W-1:0] fper;   // pixels per frame
        logic [F_W-1:0] vlen;   // vsync length in pixels
        logic [F_W-1:0] vbeg;   // window start in frame
        logic [F_W-1:0] vend;   // window end in frame, inclusive
        logic [F_W-1:0] skew;   // added to both vertical bounds
    } dtv_timing_t;
endpackage

// File: rtl/dtv_regs.sv
// Register file: holds the pending timing set, enable request, polarity
// and colour settings. Assumes single-cycle writes, no read-back.
module dtv_regs
    import dtv_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int RGB_W  = 24
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [DATA_W-1:0]   wr_data,
    output logic                en_req,
    output dtv_timing_t         pend,
    output logic                pol_hlow,
    output logic                pol_vlow,
    output logic [RGB_W-1:0]    border_col,
    output logic [RGB_W-1:0]    under_col,
    output logic                under_rec
);
    localparam int HI_LSB = 16;

    // Capture register writes; everything clears on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_req     <= 1'b0;
            pend       <= '0;
            pol_hlow   <= 1'b0;
            pol_vlow   <= 1'b0;
            border_col <= '0;
            under_col  <= '0;
            under_rec  <= 1'b0;
        end else if (wr_en) begin
            case (wr_addr)
                A_CTRL:   en_req <= wr_data[0];
                A_HSYNC: begin
                    pend.hper <= wr_data[H_W-1:0];
                    pend.hpw  <= wr_data[HI_LSB +: H_W];
                end
                A_FPER:   pend.fper <= wr_data[F_W-1:0];
                A_VLEN:   pend.vlen <= wr_data[F_W-1:0];
                A_HWIN: begin
                    pend.hbeg <= wr_data[H_W-1:0];
                    pend.hend <= wr_data[HI_LSB +: H_W];
                end
                A_VBEG:   pend.vbeg <= wr_data[F_W-1:0];
                A_VEND:   pend.vend <= wr_data[F_W-1:0];
                A_BORDER: border_col <= wr_data[RGB_W-1:0];
                A_UFLOW: begin
                    under_col <= wr_data[RGB_W-1:0];
                    under_rec <= wr_data[DATA_W-1];
                end
                A_SKEW:   pend.skew <= wr_data[F_W-1:0];
                A_POL: begin
                    pol_hlow <= wr_data[0];
                    pol_vlow <= wr_data[1];
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/dtv_seq.sv
// Sequencer: line and frame counters, run state and active timing set.
// Starts at the counter origin, loads the pending set at each frame wrap,
// and stops only at a wrap. Assumes the frame period is at least 2.
module dtv_seq
    import dtv_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en_req,
    input  dtv_timing_t     pend,
    output logic            run,
    output logic [H_W-1:0]  hcnt,
    output logic [F_W-1:0]  fcnt,
    output dtv_timing_t     act,
    output logic            frame_evt
);
    logic line_last;
    logic frame_last;

    // Detect the final pixel of a line and of a frame.
    always_comb begin
        line_last  = (hcnt == act.hper - 1'b1);
        frame_last = (fcnt == act.fper - 1'b1);
    end

    // Advance counters, shadow-load timing and handle start/stop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run       <= 1'b0;
            hcnt      <= '0;
            fcnt      <= '0;
            act       <= '0;
            frame_evt <= 1'b0;
        end else begin
            frame_evt <= 1'b0;
            if (!run) begin
                if (en_req) begin
                    run  <= 1'b1;
                    act  <= pend;
                    hcnt <= '0;
                    fcnt <= '0;
                end
            end else if (frame_last) begin
                hcnt      <= '0;
                fcnt      <= '0;
                act       <= pend;
                frame_evt <= 1'b1;
                run       <= en_req;
            end else begin
                fcnt <= fcnt + 1'b1;
                hcnt <= line_last ? '0 : hcnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/dtv_pix.sv
// Output stage: window decode, sync shaping with polarity, and colour
// selection among pixel, underflow fill, border and idle black.
// Purely combinational from the sequencer state and live settings.
module dtv_pix
    import dtv_pkg::*;
#(
    parameter int RGB_W = 24
) (
    input  logic             run,
    input  logic [H_W-1:0]   hcnt,
    input  logic [F_W-1:0]   fcnt,
    input  dtv_timing_t      act,
    input  logic             pol_hlow,
    input  logic             pol_vlow,
    input  logic [RGB_W-1:0] border_col,
    input  logic [RGB_W-1:0] under_col,
    input  logic             under_rec,
    input  logic             in_valid,
    input  logic [RGB_W-1:0] in_pix,
    output logic             de,
    output logic             hsync,
    output logic             vsync,
    output logic [RGB_W-1:0] rgb
);
    logic [F_W-1:0] vbeg_k;
    logic [F_W-1:0] vend_k;
    logic           h_in;
    logic           v_in;

    // Skew-adjusted vertical bounds and window membership.
    always_comb begin
        vbeg_k = act.vbeg + act.skew;
        vend_k = act.vend + act.skew;
        h_in   = (hcnt >= act.hbeg) && (hcnt <= act.hend);
        v_in   = (fcnt >= vbeg_k) && (fcnt <= vend_k);
        de     = run && h_in && v_in;
    end

    // Sync pulses, inverted by the polarity bits.
    always_comb begin
        hsync = (run && (hcnt < act.hpw)) ^ pol_hlow;
        vsync = (run && (fcnt < act.vlen)) ^ pol_vlow;
    end

    // Colour source selection.
    always_comb begin
        if (!run)
            rgb = '0;
        else if (!de)
            rgb = border_col;
        else if (in_valid)
            rgb = in_pix;
        else if (under_rec)
            rgb = under_col;
        else
            rgb = '0;
    end
endmodule

// File: rtl/dtv_timing_gen.sv
// Top level of the frame-linear display timing generator. Wires the
// register file, the sequencer and the output stage together.
module dtv_timing_gen
    import dtv_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int COMP_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  reg_wr,
    input  logic [ADDR_W-1:0]     reg_addr,
    input  logic [DATA_W-1:0]     reg_wdata,
    input  logic                  pix_valid,
    input  logic [3*COMP_W-1:0]   pix_data,
    output logic                  pix_ready,
    output logic [3*COMP_W-1:0]   vid_rgb,
    output logic                  vid_hsync,
    output logic                  vid_vsync,
    output logic                  vid_de,
    output logic                  frame_evt
);
    localparam int RGB_W = 3 * COMP_W;

    logic             en_req;
    dtv_timing_t      pend;
    dtv_timing_t      act;
    logic             pol_hlow;
    logic             pol_vlow;
    logic [RGB_W-1:0] border_col;
    logic [RGB_W-1:0] under_col;
    logic             under_rec;
    logic             run;
    logic [H_W-1:0]   hcnt;
    logic [F_W-1:0]   fcnt;

    dtv_regs #(.DATA_W(DATA_W), .RGB_W(RGB_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_en(reg_wr), .wr_addr(reg_addr), .wr_data(reg_wdata),
        .en_req(en_req), .pend(pend),
        .pol_hlow(pol_hlow), .pol_vlow(pol_vlow),
        .border_col(border_col), .under_col(under_col), .under_rec(under_rec)
    );

    dtv_seq u_seq (
        .clk(clk), .rst_n(rst_n),
        .en_req(en_req), .pend(pend),
        .run(run), .hcnt(hcnt), .fcnt(fcnt), .act(act),
        .frame_evt(frame_evt)
    );

    dtv_pix #(.RGB_W(RGB_W)) u_pix (
        .run(run), .hcnt(hcnt), .fcnt(fcnt), .act(act),
        .pol_hlow(pol_hlow), .pol_vlow(pol_vlow),
        .border_col(border_col), .under_col(under_col), .under_rec(under_rec),
        .in_valid(pix_valid), .in_pix(pix_data),
        .de(vid_de), .hsync(vid_hsync), .vsync(vid_vsync), .rgb(vid_rgb)
    );

    // Ready mirrors data-enable: a pixel is consumed in every window cycle.
    assign pix_ready = vid_de;
endmodule

// File: rtl/dtv_timing_gen_chk.sv
// Checker for dtv_timing_gen, attached by bind. Observes the sequencer
// state and the output ports; drives nothing.
module dtv_timing_gen_chk
    import dtv_pkg::*;
#(
    parameter int RGB_W = 24
) (
    input logic             clk,
    input logic             rst_n,
    input logic             run,
    input logic [H_W-1:0]   hcnt,
    input logic [F_W-1:0]   fcnt,
    input dtv_timing_t      act,
    input logic             under_rec,
    input logic [RGB_W-1:0] under_col,
    input logic             pix_valid,
    input logic             vid_de,
    input logic [RGB_W-1:0] vid_rgb,
    input logic             frame_evt
);
    // R11
    stop_on_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(run) |-> frame_evt);

    // R11
    evt_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_evt |=> !frame_evt);

    // R2
    start_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run) |-> (hcnt == '0) && (fcnt == '0));

    // R10
    idle_black_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> !vid_de && (vid_rgb == '0));

    // R5
    de_hwin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vid_de |-> run && (hcnt >= act.hbeg) && (hcnt <= act.hend));

    // R9
    under_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vid_de && !pix_valid && under_rec |-> vid_rgb == under_col);

    // R12
    shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run && $past(run) && (fcnt != '0) |-> $stable(act));
endmodule

bind dtv_timing_gen dtv_timing_gen_chk #(.RGB_W(RGB_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .run(run), .hcnt(hcnt), .fcnt(fcnt),
    .act(act), .under_rec(under_rec), .under_col(under_col),
    .pix_valid(pix_valid), .vid_de(vid_de), .vid_rgb(vid_rgb),
    .frame_evt(frame_evt)
);

// File: tb/sim_dtv_timing_gen.sv
`timescale 1ns/1ps
// Directed bench: a behavioural model built from the requirements runs
// beside the design, and each scenario task compares every output in
// every cycle it covers.
module sim_dtv_timing_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic        pix_valid = 1'b0;
    logic [23:0] pix_data = '0;
    logic        pix_ready, vid_hsync, vid_vsync, vid_de, frame_evt;
    logic [23:0] vid_rgb;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    logic cmp_on = 1'b0;
    string tag = "R1";

    always #2.5 clk = ~clk;

    dtv_timing_gen u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .pix_valid(pix_valid), .pix_data(pix_data),
        .pix_ready(pix_ready), .vid_rgb(vid_rgb), .vid_hsync(vid_hsync),
        .vid_vsync(vid_vsync), .vid_de(vid_de), .frame_evt(frame_evt)
    );

    // ---------------- requirement model ----------------
    int p_hper, p_hpw, p_hbeg, p_hend, p_fper, p_vlen, p_vbeg, p_vend, p_skew;
    int a_hper, a_hpw, a_hbeg, a_hend, a_fper, a_vlen, a_vbeg, a_vend, a_skew;
    int m_h, m_f;
    logic m_en, m_run, m_evt, m_ph, m_pv, m_rec;
    logic [23:0] m_border, m_under;

    always @(posedge clk) begin
        if (!rst_n) begin
            {p_hper, p_hpw, p_hbeg, p_hend, p_fper, p_vlen, p_vbeg, p_vend, p_skew} = '0;
            {a_hper, a_hpw, a_hbeg, a_hend, a_fper, a_vlen, a_vbeg, a_vend, a_skew} = '0;
            m_h = 0; m_f = 0; m_en = 0; m_run = 0; m_evt = 0;
            m_ph = 0; m_pv = 0; m_rec = 0; m_border = '0; m_under = '0;
        end else begin
            logic en_old;
            logic start, wrap;
            en_old = m_en;
            start = !m_run && en_old;
            wrap  = m_run && (m_f == a_fper - 1);
            m_evt = wrap;
            if (start || wrap) begin
                {a_hper, a_hpw, a_hbeg, a_hend, a_fper, a_vlen, a_vbeg, a_vend, a_skew} =
                    {p_hper, p_hpw, p_hbeg, p_hend, p_fper, p_vlen, p_vbeg, p_vend, p_skew};
                m_h = 0; m_f = 0;
                m_run = start ? 1'b1 : en_old;
            end else if (m_run) begin
                m_f = m_f + 1;
                m_h = (m_h == a_hper - 1) ? 0 : m_h + 1;
            end
            if (reg_wr) begin
                case (reg_addr)
                    4'd0:  m_en = reg_wdata[0];
                    4'd1:  begin p_hper = int'(reg_wdata[11:0]); p_hpw = int'(reg_wdata[27:16]); end
                    4'd2:  p_fper = int'(reg_wdata[23:0]);
                    4'd3:  p_vlen = int'(reg_wdata[23:0]);
                    4'd4:  begin p_hbeg = int'(reg_wdata[11:0]); p_hend = int'(reg_wdata[27:16]); end
                    4'd5:  p_vbeg = int'(reg_wdata[23:0]);
                    4'd6:  p_vend = int'(reg_wdata[23:0]);
                    4'd7:  m_border = reg_wdata[23:0];
                    4'd8:  begin m_under = reg_wdata[23:0]; m_rec = reg_wdata[31]; end
                    4'd9:  p_skew = int'(reg_wdata[23:0]);
                    4'd10: begin m_ph = reg_wdata[0]; m_pv = reg_wdata[1]; end
                    default: ;
                endcase
            end
        end
    end

    task automatic chk(input string req, input logic [23:0] got, input logic [23:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s [%s] cycle %0d got=%h exp=%h", req, tag, cyc, got, exp);
        end
    endtask

    // Compare every output against the model shortly after each falling edge.
    always @(negedge clk) begin
        cyc++;
        if (cmp_on) begin
            logic de_e, hs_e, vs_e;
            logic [23:0] rgb_e;
            #1;
            de_e = m_run && m_h >= a_hbeg && m_h <= a_hend &&
                   m_f >= a_vbeg + a_skew && m_f <= a_vend + a_skew;
            hs_e = (m_run && m_h < a_hpw) ^ m_ph;
            vs_e = (m_run && m_f < a_vlen) ^ m_pv;
            if (!m_run)         rgb_e = '0;
            else if (!de_e)     rgb_e = m_border;
            else if (pix_valid) rgb_e = pix_data;
            else if (m_rec)     rgb_e = m_under;
            else                rgb_e = '0;
            chk("R3", {23'd0, vid_hsync}, {23'd0, hs_e});
            chk("R4", {23'd0, vid_vsync}, {23'd0, vs_e});
            chk("R6", {23'd0, vid_de}, {23'd0, de_e});
            chk("R6", {23'd0, pix_ready}, {23'd0, de_e});
            chk(!m_run ? "R10" : !de_e ? "R10" : pix_valid ? "R8" : "R9", vid_rgb, rgb_e);
            chk("R11", {23'd0, frame_evt}, {23'd0, m_evt});
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(5.0 * 150000);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    // ---------------- stimulus helpers ----------------
    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        pix_data = pix_data + 24'h010203;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic step(input int n, input logic valid);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            pix_valid = valid;
            pix_data  = pix_data + 24'h071305;
        end
    endtask

    // ---------------- scenarios ----------------
    // R1: idle state after reset, syncs low, no data-enable.
    task automatic t_reset();
        tag = "reset R1";
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        cmp_on = 1'b1;
        step(4, 1'b1);
        chk("R1", {23'd0, vid_de | frame_evt | vid_hsync | vid_vsync}, 24'd0);
    endtask

    // R2 R3 R4 R5 R6 R8 R10: program a 10x6 frame, enable, watch two frames.
    task automatic t_frame();
        tag = "frame R2 R5";
        wr(4'd1, {4'd0, 12'd2, 4'd0, 12'd10});
        wr(4'd2, 32'd60);
        wr(4'd3, 32'd10);
        wr(4'd4, {4'd0, 12'd8, 4'd0, 12'd4});
        wr(4'd5, 32'd20);
        wr(4'd6, 32'd49);
        wr(4'd7, 32'h00123456);
        wr(4'd0, 32'd1);
        step(125, 1'b1);
    endtask

    // R9: underflow with recovery on, then off.
    task automatic t_underflow();
        tag = "underflow R9";
        wr(4'd8, 32'h800000FF);
        step(60, 1'b0);
        wr(4'd8, 32'h000000FF);
        step(60, 1'b0);
    endtask

    // R7: both syncs active-low.
    task automatic t_polarity();
        tag = "polarity R7";
        wr(4'd10, 32'd3);
        step(70, 1'b1);
        wr(4'd10, 32'd0);
    endtask

    // R12: skew and new line timing written mid-frame apply from next frame.
    task automatic t_shadow();
        tag = "shadow R12";
        step(7, 1'b1);
        wr(4'd9, 32'd10);
        wr(4'd1, {4'd0, 12'd3, 4'd0, 12'd12});
        wr(4'd2, 32'd72);
        wr(4'd4, {4'd0, 12'd10, 4'd0, 12'd5});
        step(160, 1'b1);
    endtask

    // R11: clearing enable finishes the frame, pulses the event, then idles.
    task automatic t_stop();
        tag = "stop R11";
        step(15, 1'b1);
        wr(4'd0, 32'd0);
        step(100, 1'b1);
        chk("R11", {23'd0, vid_de | vid_hsync | vid_vsync}, 24'd0);
        tag = "restart R2";
        wr(4'd0, 32'd1);
        step(80, 1'b1);
    endtask

    initial begin
        t_reset();
        t_frame();
        t_underflow();
        t_polarity();
        t_shadow();
        t_stop();
        cmp_on = 1'b0;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule